// File: doc/BRIEF.md
# Sharing-Aware Victim Cache

This block is a set-associative last-level cache shared by several cores. It fills only with lines that a core's private second-level cache has thrown out. Those lines arrive on an insert port, carrying their address, their data and the ID of the core that evicted them. A separate lookup port takes an address and a core ID. One cycle later it answers with hit or miss, plus the data on a hit. A miss allocates nothing: the requester fetches the line from elsewhere and places it straight in its own first-level cache.

Each line records the core that last inserted it and a sticky shared flag. The flag is set as soon as a different core hits the line. A hit on a shared line keeps the line in the cache, which is inclusive behaviour. A hit by the owner on an unshared line hands the data back and frees the way, which is exclusive behaviour. When an insert needs a way, the cache takes an empty way first, then an unshared line, then a shared one. Ties within a class go to a per-set rotating pointer. An insert whose address is already present overwrites that copy in place.

The lookup address splits into a set index in the low `$clog2(NUM_SETS)` bits and a tag in the remaining upper bits.

Top module: `shv_cache`

## Requirements
- R1: A lookup that misses returns rsp_hit=0 and rsp_data=0, and allocates nothing: repeating the same lookup still misses.
- R2: An inserted line is found by a later lookup to its address from any core, and the response carries the inserted data.
- R3: A lookup hit from a core other than the line's last inserter marks the line shared. A hit on a shared line returns the data and leaves the line valid, so later lookups from any core, the owner included, still hit.
- R4: A lookup hit from the owning core on an unshared line returns the data and invalidates the line, so the next lookup to that address misses.
- R5: On an allocating insert, an invalid way of the set is always chosen when one exists.
- R6: When the set is full, an unshared line is replaced before any shared line.
- R7: Within a class, the search for a victim starts at the set's rotating pointer and moves upward, wrapping around. After each allocating insert the pointer moves to one past the way just written.
- R8: An insert whose address already hits overwrites that way's data and owner, keeps its shared flag, and creates no second copy.
- R9: ins_ready is always 1, and lk_ready is 0 whenever ins_valid is 1. A lookup offered in such a cycle is not accepted and produces no response.
- R10: rsp_valid is 1 in exactly the cycle after an accepted lookup and 0 otherwise. rsp_hit and rsp_data are 0 whenever rsp_valid is 0.
- R11: After reset, every line is invalid, every rotating pointer is 0 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_ready_o | output | 1 | Lookup request accepted this cycle |
| lk_addr_i | input | ADDR_W | Lookup line address |
| lk_core_i | input | CORE_W | Requesting core ID |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_data_o | output | DATA_W | Line data on a hit |
| ins_valid_i | input | 1 | Victim insert valid |
| ins_ready_o | output | 1 | Victim insert accepted |
| ins_addr_i | input | ADDR_W | Victim line address |
| ins_data_i | input | DATA_W | Victim line data |
| ins_core_i | input | CORE_W | Evicting core ID |

## Verification
The bench builds the cache with 4 sets, 8 ways, 4 cores, a 10-bit address and 16-bit data. With so few sets, each set fills, overflows and wraps its rotating pointer many times within a few thousand operations. A reference model in the bench tracks every line and every pointer, and it checks each lookup response during a long pseudo-random stream. The tag range in that stream is kept small so that hits, private drops, shared retains and duplicate inserts all occur often. Directed sequences in separate sets fix the victim order for the empty-first, private-first and pointer-rotation cases. One further sequence offers a lookup and an insert in the same cycle.

// File: rtl/shv_pkg.sv
package shv_pkg;

   // replacement class, in order of preference
   typedef enum logic [1:0] {
      CLS_EMPTY   = 2'd0,
      CLS_PRIVATE = 2'd1,
      CLS_SHARED  = 2'd2
   } vic_class_e;

endpackage

// File: rtl/shv_way_match.sv
module shv_way_match #(
   parameter int WAYS  = 8,
   parameter int TAG_W = 12,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [WAYS-1:0]             vld_i,
   input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
   input  logic [TAG_W-1:0]            tag_i,
   output logic                        hit_o,
   output logic [WAY_W-1:0]            way_o
);

   logic [WAYS-1:0] hit_vec;
   logic            found;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = vld_i[w] && (tags_i[w] == tag_i);
   end

   assign hit_o = |hit_vec;

   always_comb begin
      way_o = '0;
      found = 1'b0;
      for (int i = 0; i < WAYS; i++) begin
         if (!found && hit_vec[i]) begin
            way_o = WAY_W'(i);
            found = 1'b1;
         end
      end
   end

   // R8
   single_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hit_vec));

endmodule

// File: rtl/shv_repl_pick.sv
module shv_repl_pick
   import shv_pkg::*;
#(
   parameter int WAYS = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic [WAYS-1:0]   vld_i,
   input  logic [WAYS-1:0]   shr_i,
   input  logic [WAY_W-1:0]  ptr_i,
   output logic [WAY_W-1:0]  way_o
);

   logic [WAYS-1:0]  empty_m, priv_m, shar_m, sel_m;
   vic_class_e       cls;
   logic [WAY_W-1:0] idx;
   logic             found;

   assign empty_m = ~vld_i;
   assign priv_m  = vld_i & ~shr_i;
   assign shar_m  = vld_i & shr_i;

   always_comb begin
      if (|empty_m)     cls = CLS_EMPTY;
      else if (|priv_m) cls = CLS_PRIVATE;
      else              cls = CLS_SHARED;
      case (cls)
         CLS_EMPTY:   sel_m = empty_m;
         CLS_PRIVATE: sel_m = priv_m;
         default:     sel_m = shar_m;
      endcase
   end

   // rotating search starting at the set pointer
   always_comb begin
      way_o = '0;
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < WAYS; i++) begin
         idx = ptr_i + WAY_W'(i);
         if (!found && sel_m[idx]) begin
            way_o = idx;
            found = 1'b1;
         end
      end
   end

   // R5
   empty_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !(&vld_i)) |-> !vld_i[way_o]);

   // R6
   private_before_shared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && (&vld_i) && !(&shr_i)) |-> !shr_i[way_o]);

endmodule

// File: rtl/shv_cache.sv
module shv_cache #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int NUM_SETS  = 16,
   parameter int NUM_WAYS  = 8,
   parameter int NUM_CORES = 4,
   localparam int SET_W  = $clog2(NUM_SETS),
   localparam int TAG_W  = ADDR_W - SET_W,
   localparam int WAY_W  = $clog2(NUM_WAYS),
   localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              lk_valid_i,
   output logic              lk_ready_o,
   input  logic [ADDR_W-1:0] lk_addr_i,
   input  logic [CORE_W-1:0] lk_core_i,
   output logic              rsp_valid_o,
   output logic              rsp_hit_o,
   output logic [DATA_W-1:0] rsp_data_o,
   input  logic              ins_valid_i,
   output logic              ins_ready_o,
   input  logic [ADDR_W-1:0] ins_addr_i,
   input  logic [DATA_W-1:0] ins_data_i,
   input  logic [CORE_W-1:0] ins_core_i
);

   // elaboration-time parameter checks
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the set index width");
   end
   if (NUM_CORES < 2) begin : g_bad_cores
      $error("NUM_CORES must be at least 2");
   end

   // per-set state, exported from the set blocks
   logic [NUM_WAYS-1:0]              vld_q [NUM_SETS];
   logic [NUM_WAYS-1:0]              shr_q [NUM_SETS];
   logic [NUM_WAYS-1:0][TAG_W-1:0]   tag_q [NUM_SETS];
   logic [NUM_WAYS-1:0][CORE_W-1:0]  own_q [NUM_SETS];
   logic [NUM_WAYS-1:0][DATA_W-1:0]  dat_q [NUM_SETS];
   logic [WAY_W-1:0]                 rr_q  [NUM_SETS];

   // one operation per cycle: insert wins
   logic              ins_fire, lk_fire;
   logic [ADDR_W-1:0] op_addr;
   logic [SET_W-1:0]  op_set;
   logic [TAG_W-1:0]  op_tag;
   logic              op_hit;
   logic [WAY_W-1:0]  op_way;
   logic [WAY_W-1:0]  vic_way;
   logic              keep_line;

   logic [NUM_WAYS-1:0]             cur_vld, cur_shr;
   logic [NUM_WAYS-1:0][TAG_W-1:0]  cur_tag;
   logic [NUM_WAYS-1:0][CORE_W-1:0] cur_own;
   logic [NUM_WAYS-1:0][DATA_W-1:0] cur_dat;
   logic [WAY_W-1:0]                cur_rr;

   assign ins_ready_o = 1'b1;
   assign lk_ready_o  = !ins_valid_i;
   assign ins_fire    = ins_valid_i;
   assign lk_fire     = lk_valid_i && lk_ready_o;

   assign op_addr = ins_valid_i ? ins_addr_i : lk_addr_i;
   assign op_set  = op_addr[SET_W-1:0];
   assign op_tag  = op_addr[ADDR_W-1:SET_W];

   assign cur_vld = vld_q[op_set];
   assign cur_shr = shr_q[op_set];
   assign cur_tag = tag_q[op_set];
   assign cur_own = own_q[op_set];
   assign cur_dat = dat_q[op_set];
   assign cur_rr  = rr_q[op_set];

   // a hit from a foreign core counts as sharing before the keep/drop choice
   assign keep_line = cur_shr[op_way] || (cur_own[op_way] != lk_core_i);

   shv_way_match #(
      .WAYS  (NUM_WAYS),
      .TAG_W (TAG_W)
   ) u_match (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (cur_vld),
      .tags_i (cur_tag),
      .tag_i  (op_tag),
      .hit_o  (op_hit),
      .way_o  (op_way)
   );

   shv_repl_pick #(
      .WAYS (NUM_WAYS)
   ) u_pick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ins_fire && !op_hit),
      .vld_i  (cur_vld),
      .shr_i  (cur_shr),
      .ptr_i  (cur_rr),
      .way_o  (vic_way)
   );

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic [NUM_WAYS-1:0]             vld_s, shr_s;
      logic [NUM_WAYS-1:0][TAG_W-1:0]  tag_s;
      logic [NUM_WAYS-1:0][CORE_W-1:0] own_s;
      logic [NUM_WAYS-1:0][DATA_W-1:0] dat_s;
      logic [WAY_W-1:0]                rr_s;
      logic                            sel;

      assign sel = (op_set == SET_W'(s));

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            vld_s <= '0;
            shr_s <= '0;
            tag_s <= '0;
            own_s <= '0;
            dat_s <= '0;
            rr_s  <= '0;
         end else if (sel && ins_fire) begin
            if (op_hit) begin
               dat_s[op_way] <= ins_data_i;
               own_s[op_way] <= ins_core_i;
            end else begin
               vld_s[vic_way] <= 1'b1;
               shr_s[vic_way] <= 1'b0;
               tag_s[vic_way] <= op_tag;
               own_s[vic_way] <= ins_core_i;
               dat_s[vic_way] <= ins_data_i;
               rr_s           <= vic_way + WAY_W'(1);
            end
         end else if (sel && lk_fire && op_hit) begin
            if (keep_line) shr_s[op_way] <= 1'b1;
            else           vld_s[op_way] <= 1'b0;
         end
      end

      assign vld_q[s] = vld_s;
      assign shr_q[s] = shr_s;
      assign tag_q[s] = tag_s;
      assign own_q[s] = own_s;
      assign dat_q[s] = dat_s;
      assign rr_q[s]  = rr_s;
   end

   // response stage: fixed one-cycle latency
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rsp_valid_o <= 1'b0;
         rsp_hit_o   <= 1'b0;
         rsp_data_o  <= '0;
      end else begin
         rsp_valid_o <= lk_fire;
         rsp_hit_o   <= lk_fire && op_hit;
         rsp_data_o  <= (lk_fire && op_hit) ? cur_dat[op_way] : '0;
      end
   end

   // R9
   blocked_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_valid_i && ins_valid_i) |=> !rsp_valid_o);

   // R10
   rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_valid_i && lk_ready_o) |=> rsp_valid_o);

   // R10
   rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lk_valid_i && lk_ready_o) |=> !rsp_valid_o);

   // R10
   rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rsp_valid_o |-> (!rsp_hit_o && rsp_data_o == '0));

endmodule

// File: tb/shv_cache_bench.sv
`timescale 1ns/1ps
module shv_cache_bench;

   localparam int SETS  = 4;
   localparam int WAYS  = 8;
   localparam int CORES = 4;
   localparam int AW    = 10;
   localparam int DW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0, lk_ready;
   logic [AW-1:0] lk_addr = '0;
   logic [1:0]    lk_core = '0;
   logic          rsp_valid, rsp_hit;
   logic [DW-1:0] rsp_data;
   logic          ins_valid = 1'b0, ins_ready;
   logic [AW-1:0] ins_addr = '0;
   logic [DW-1:0] ins_data = '0;
   logic [1:0]    ins_core = '0;

   always #10 clk = ~clk;

   shv_cache #(
      .ADDR_W(AW), .DATA_W(DW), .NUM_SETS(SETS), .NUM_WAYS(WAYS), .NUM_CORES(CORES)
   ) u_shv_cache (
      .clk_i(clk), .rst_ni(rst_n),
      .lk_valid_i(lk_valid), .lk_ready_o(lk_ready), .lk_addr_i(lk_addr), .lk_core_i(lk_core),
      .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_data_o(rsp_data),
      .ins_valid_i(ins_valid), .ins_ready_o(ins_ready), .ins_addr_i(ins_addr),
      .ins_data_i(ins_data), .ins_core_i(ins_core)
   );

   int  vectors = 0;
   int  fails = 0;
   bit  done = 1'b0;

   // reference model
   bit      m_vld [SETS][WAYS];
   bit      m_shr [SETS][WAYS];
   int      m_tag [SETS][WAYS];
   int      m_own [SETS][WAYS];
   int      m_dat [SETS][WAYS];
   int      m_rr  [SETS];

   bit      got_hit;
   int      got_data;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int m_find(input int s, input int t);
      for (int w = 0; w < WAYS; w++)
         if (m_vld[s][w] && m_tag[s][w] == t) return w;
      return -1;
   endfunction

   function automatic int m_pick(input int s);
      for (int c = 0; c < 3; c++)
         for (int i = 0; i < WAYS; i++) begin
            int w = (m_rr[s] + i) % WAYS;
            if (c == 0 && !m_vld[s][w]) return w;
            if (c == 1 && m_vld[s][w] && !m_shr[s][w]) return w;
            if (c == 2 && m_vld[s][w] && m_shr[s][w]) return w;
         end
      return 0;
   endfunction

   task automatic m_insert(input int s, input int t, input int core, input int d);
      int w = m_find(s, t);
      if (w >= 0) begin
         m_dat[s][w] = d;
         m_own[s][w] = core;
      end else begin
         w = m_pick(s);
         m_vld[s][w] = 1'b1; m_shr[s][w] = 1'b0;
         m_tag[s][w] = t; m_own[s][w] = core; m_dat[s][w] = d;
         m_rr[s] = (w + 1) % WAYS;
      end
   endtask

   task automatic m_lookup(input int s, input int t, input int core, output bit h, output int d);
      int w = m_find(s, t);
      h = (w >= 0);
      d = 0;
      if (h) begin
         d = m_dat[s][w];
         if (m_shr[s][w] || m_own[s][w] != core) m_shr[s][w] = 1'b1;
         else m_vld[s][w] = 1'b0;
      end
   endtask

   task automatic do_insert(input int s, input int t, input int core, input int d);
      m_insert(s, t, core, d);
      @(negedge clk);
      ins_valid = 1'b1; ins_addr = {8'(t), 2'(s)}; ins_core = 2'(core); ins_data = DW'(d);
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   task automatic do_lookup(input int s, input int t, input int core, input string req);
      bit eh; int ed;
      m_lookup(s, t, core, eh, ed);
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = {8'(t), 2'(s)}; lk_core = 2'(core);
      @(negedge clk);
      lk_valid = 1'b0;
      got_hit = rsp_hit;
      got_data = int'(rsp_data);
      chk(rsp_valid && rsp_hit == eh && int'(rsp_data) == ed, req,
          {rsp_valid, rsp_hit, rsp_data}, {1'b1, eh, DW'(ed)});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int unsigned lfsr = 32'h1234_5678;
      for (int s = 0; s < SETS; s++) begin
         m_rr[s] = 0;
         for (int w = 0; w < WAYS; w++) begin
            m_vld[s][w] = 0; m_shr[s][w] = 0; m_tag[s][w] = 0; m_own[s][w] = 0; m_dat[s][w] = 0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: quiet, empty after reset
      @(negedge clk);
      chk(!rsp_valid && lk_ready && ins_ready, "R11", {rsp_valid, lk_ready, ins_ready}, 3'b011);
      for (int s = 0; s < SETS; s++)
         for (int t = 0; t < 3; t++) begin
            do_lookup(s, t, t % CORES, "R11");
            chk(!got_hit, "R11", got_hit, 0);
         end

      // R1: miss allocates nothing
      do_lookup(1, 40, 0, "R1");
      do_lookup(1, 40, 0, "R1");
      chk(!got_hit && got_data == 0, "R1", {got_hit, got_data}, 0);

      // R2 and R4: private hit is handed back and dropped
      do_insert(1, 41, 0, 16'hA1A1);
      do_lookup(1, 41, 0, "R2");
      chk(got_hit && got_data == 16'hA1A1, "R2", got_data, 16'hA1A1);
      do_lookup(1, 41, 0, "R4");
      chk(!got_hit, "R4", got_hit, 0);

      // R3: foreign hit marks shared, owner hit keeps it
      do_insert(1, 42, 0, 16'hB2B2);
      do_lookup(1, 42, 1, "R3");
      do_lookup(1, 42, 0, "R3");
      do_lookup(1, 42, 2, "R3");
      chk(got_hit && got_data == 16'hB2B2, "R3", got_data, 16'hB2B2);

      // R8: reinsertion of a shared line keeps it shared
      do_insert(1, 42, 3, 16'hC3C3);
      do_lookup(1, 42, 3, "R8");
      do_lookup(1, 42, 3, "R8");
      chk(got_hit && got_data == 16'hC3C3, "R8", got_data, 16'hC3C3);
      // R8: duplicate private insert yields one copy
      do_insert(1, 43, 0, 16'h1111);
      do_insert(1, 43, 0, 16'h2222);
      do_lookup(1, 43, 0, "R8");
      chk(got_hit && got_data == 16'h2222, "R8", got_data, 16'h2222);
      do_lookup(1, 43, 0, "R8");
      chk(!got_hit, "R8", got_hit, 0);

      // R5: a hole left by a private drop is refilled before any rotation
      for (int t = 1; t <= WAYS; t++) do_insert(0, t, 0, 16'h0100 + t);
      do_lookup(0, 5, 0, "R5");
      do_insert(0, 9, 0, 16'h0109);
      do_lookup(0, 1, 2, "R5");
      chk(got_hit, "R5", got_hit, 1);
      do_lookup(0, 9, 2, "R5");
      chk(got_hit && got_data == 16'h0109, "R5", got_data, 16'h0109);

      // R6: unshared lines go before shared ones
      for (int t = 1; t <= WAYS; t++) do_insert(2, t, 0, 16'h0200 + t);
      do_lookup(2, 1, 1, "R6");
      do_lookup(2, 3, 1, "R6");
      do_insert(2, 9, 0, 16'h0209);
      do_insert(2, 10, 0, 16'h020A);
      do_lookup(2, 2, 1, "R6");
      chk(!got_hit, "R6", got_hit, 0);
      do_lookup(2, 4, 1, "R6");
      chk(!got_hit, "R6", got_hit, 0);
      do_lookup(2, 1, 1, "R6");
      chk(got_hit, "R6", got_hit, 1);
      do_lookup(2, 3, 1, "R6");
      chk(got_hit, "R6", got_hit, 1);

      // R7: rotating pointer spreads replacements
      for (int t = 1; t <= WAYS; t++) do_insert(3, t, 0, 16'h0300 + t);
      do_insert(3, 9, 0, 16'h0309);
      do_insert(3, 10, 0, 16'h030A);
      do_lookup(3, 9, 1, "R7");
      chk(got_hit, "R7", got_hit, 1);
      do_lookup(3, 2, 1, "R7");
      chk(!got_hit, "R7", got_hit, 0);
      do_lookup(3, 3, 1, "R7");
      chk(got_hit, "R7", got_hit, 1);

      // R9: insert blocks a lookup offered in the same cycle
      m_insert(1, 50, 2, 16'h5050);
      @(negedge clk);
      ins_valid = 1'b1; ins_addr = {8'd50, 2'd1}; ins_core = 2'd2; ins_data = 16'h5050;
      lk_valid = 1'b1; lk_addr = {8'd50, 2'd1}; lk_core = 2'd2;
      #1;
      chk(!lk_ready && ins_ready, "R9", {lk_ready, ins_ready}, 2'b01);
      @(negedge clk);
      chk(!rsp_valid, "R9", rsp_valid, 0);
      ins_valid = 1'b0;
      #1;
      chk(lk_ready, "R9", lk_ready, 1);
      begin
         bit eh; int ed;
         m_lookup(1, 50, 2, eh, ed);
         @(negedge clk);
         lk_valid = 1'b0;
         // R10: response exactly one cycle after acceptance
         chk(rsp_valid && rsp_hit == eh && int'(rsp_data) == ed, "R10",
             {rsp_valid, rsp_hit, rsp_data}, {1'b1, eh, DW'(ed)});
      end
      @(negedge clk);
      chk(!rsp_valid && !rsp_hit && rsp_data == 0, "R10", {rsp_valid, rsp_hit, rsp_data}, 0);

      // pseudo-random stream against the model
      for (int n = 0; n < 4000; n++) begin
         int s, t, c, d;
         lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
         s = int'(lfsr[1:0]);
         t = int'(lfsr[6:3]) + 100;
         c = int'(lfsr[9:8]);
         d = int'(lfsr[31:16]);
         if (lfsr[12]) do_insert(s, t, c, d);
         else          do_lookup(s, t, c, "R3_R4_R8");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule